// File: doc/BRIEF.md
# Time-Shifted Triple Sampling Voter

This block guards a single combinational result against short transient pulses. It uses one copy of the logic and three sampling instants instead of three copies of the logic. It runs on a fast clock. A start strobe marks the beginning of a sampling period. The block then captures the data input three times, spaced `D_STEP` fast cycles apart, at offsets 0, d and 2d. It forms the bitwise majority of the three captures and loads that majority into the output register at offset 3d.

A pulse that lasts fewer than `D_STEP` fast cycles can reach at most one of the three captures, so the vote removes it. A flag registered with the output shows whether the three captures differed, even when the voted word is correct.

Sequencing uses a four-state machine with a step counter. The states are `ST_IDLE`, `ST_GAP0`, `ST_GAP1` and `ST_GAP2`, and the transitions are:
- **accept**: `ST_IDLE` to `ST_GAP0` on start. The first capture is taken here.
- **second_take**: `ST_GAP0` to `ST_GAP1` when the counter reaches `D_STEP-1`.
- **third_take**: `ST_GAP1` to `ST_GAP2` when the counter reaches `D_STEP-1`.
- **commit**: `ST_GAP2` to `ST_IDLE` when the counter reaches `D_STEP-1`. The voted word is loaded here.

In every other case the machine holds its state and advances the counter. An elaboration-time check rejects parameter sets where `3*D_STEP` does not fit inside `PERIOD`.

Top module: `tsv_voter`

## Requirements
- R1: After reset, `vote_q`, `vote_vld` and `split_q` are all 0.
- R2: When `start` is high in the idle state, the first capture takes `din` at that same rising edge (offset 0).
- R3: The second capture takes `din` at the edge `D_STEP` fast cycles after the accept edge. The third capture takes `din` at the edge `2*D_STEP` cycles after the accept edge.
- R4: Each bit of the voted word is 1 exactly when at least two of the three captured bits at that position are 1.
- R5: `vote_q` takes the voted word at the edge `3*D_STEP` cycles after the accept edge. `vote_vld` is high for exactly the one fast cycle that follows that edge.
- R6: If `din` deviates from a steady value for fewer than `D_STEP` cycles, `vote_q` still shows the steady value.
- R7: `split_q` is loaded together with `vote_q`. It is 1 when the three captures are not all equal and 0 when they are all equal.
- R8: A `start` that arrives while a period is in progress has no effect: the sequence, its capture instants and its commit edge are unchanged.
- R9: Between commits, `vote_q` and `split_q` keep their values regardless of `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start-of-period strobe |
| din | input | WIDTH | Combinational result under protection |
| vote_q | output | WIDTH | Registered majority of the three captures |
| vote_vld | output | 1 | One-cycle pulse when `vote_q` is updated |
| split_q | output | 1 | High when the last three captures disagreed |

## Verification
The steady-input pattern shows that the three capture instants and the commit edge fall exactly where R5 expects, since any stray instant would still vote correctly but shift `vote_vld`.

The pattern with three distinct words, one per capture window, distinguishes a true per-bit vote from one that copies any single capture. It also confirms that the flag rises. A one-cycle pulse placed on the second, and then on the third, capture instant shows that a short deviation is removed while the flag still reports it.

Strobes sent mid-period, and data that changes while idle, show that neither disturbs the sequence or the held outputs.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP0 = 2'd1,
        ST_GAP1 = 2'd2,
        ST_GAP2 = 2'd3
    } tsv_state_e;

    localparam int unsigned N_TAKES = 3;
endpackage

// File: rtl/tsv_phase_ctrl.sv
module tsv_phase_ctrl
    import tsv_pkg::*;
#(
    parameter int unsigned D_STEP = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic [N_TAKES-1:0]   take,
    output logic                 commit,
    output logic                 busy
);
    localparam int unsigned CW = $clog2(D_STEP + 1);
    localparam logic [CW-1:0] LAST = CW'(D_STEP - 1);

    tsv_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            at_last;

    assign at_last = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_GAP0;
                    cnt_d   = '0;
                end
            end
            ST_GAP0: begin
                if (at_last) begin
                    state_d = ST_GAP1;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_GAP1: begin
                if (at_last) begin
                    state_d = ST_GAP2;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_GAP2: begin
                if (at_last) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take    = '0;
        commit  = 1'b0;
        busy    = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: take[0] = start;
            ST_GAP0: take[1] = at_last;
            ST_GAP1: take[2] = at_last;
            ST_GAP2: commit  = at_last;
            default: ;
        endcase
    end

    // R3: capture strobes and commit never coincide
    assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take, commit}));

    // R5: a commit returns the machine to idle on the next cycle
    assert_commit_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
endmodule

// File: rtl/tsv_sample_bank.sv
module tsv_sample_bank
    import tsv_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [N_TAKES-1:0]                 take,
    input  logic [WIDTH-1:0]                   din,
    output logic [N_TAKES-1:0][WIDTH-1:0]      samp
);
    for (genvar g = 0; g < N_TAKES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       samp[g] <= '0;
            else if (take[g]) samp[g] <= din;
        end

        // R2: each lane holds the input present at its strobe
        assert_lane_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
            take[g] |=> (samp[g] == $past(din)));
    end
endmodule

// File: rtl/tsv_maj_voter.sv
module tsv_maj_voter
    import tsv_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [N_TAKES-1:0][WIDTH-1:0] samp,
    output logic [WIDTH-1:0]              maj,
    output logic                          split
);
    always_comb begin
        maj   = (samp[0] & samp[1]) | (samp[0] & samp[2]) | (samp[1] & samp[2]);
        split = |((samp[0] ^ samp[1]) | (samp[1] ^ samp[2]));
    end
endmodule

// File: rtl/tsv_voter.sv
module tsv_voter
    import tsv_pkg::*;
#(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned D_STEP = 2,
    parameter int unsigned PERIOD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WIDTH-1:0]  din,
    output logic [WIDTH-1:0]  vote_q,
    output logic              vote_vld,
    output logic              split_q
);
    localparam int unsigned SPAN = N_TAKES * D_STEP;

    if (D_STEP < 1 || SPAN >= PERIOD) begin : g_bad_params
        $error("tsv_voter: 3*D_STEP must be at least 3 and below PERIOD");
    end

    logic [N_TAKES-1:0]              take;
    logic                            commit;
    logic                            busy;
    logic [N_TAKES-1:0][WIDTH-1:0]   samp;
    logic [WIDTH-1:0]                maj;
    logic                            split;

    tsv_phase_ctrl #(.D_STEP(D_STEP)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .take   (take),
        .commit (commit),
        .busy   (busy)
    );

    tsv_sample_bank #(.WIDTH(WIDTH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .din   (din),
        .samp  (samp)
    );

    tsv_maj_voter #(.WIDTH(WIDTH)) u_vote (
        .samp  (samp),
        .maj   (maj),
        .split (split)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vote_q   <= '0;
            vote_vld <= 1'b0;
            split_q  <= 1'b0;
        end else begin
            vote_vld <= commit;
            if (commit) begin
                vote_q  <= maj;
                split_q <= split;
            end
        end
    end

    // R5: the valid pulse lasts a single fast cycle
    assert_vld_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vote_vld |=> !vote_vld);

    // R9: outputs hold between commits
    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(vote_q) && $stable(split_q)));

    // R8: a strobe during a period leaves the first capture untouched
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(samp[0]));
endmodule

// File: tb/sim_tsv_voter.sv
module sim_tsv_voter;
    localparam int W = 8;
    localparam int D = 2;
    localparam int P = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] vote_q;
    logic         vote_vld;
    logic         split_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    bit           m_busy = 1'b0;
    int           m_off = 0;
    logic [W-1:0] m_s [3];
    logic [W-1:0] m_dout = '0;
    bit           m_vld = 1'b0;
    bit           m_split = 1'b0;

    always #5 clk = ~clk;

    tsv_voter #(.WIDTH(W), .D_STEP(D), .PERIOD(P)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .din(din),
        .vote_q(vote_q), .vote_vld(vote_vld), .split_q(split_q)
    );

    task automatic model_edge(input bit st, input logic [W-1:0] d);
        m_vld = 1'b0;
        if (!m_busy) begin
            if (st) begin
                m_busy = 1'b1;
                m_off  = 0;
                m_s[0] = d;
            end
        end else begin
            m_off++;
            if (m_off == D)     m_s[1] = d;
            if (m_off == 2 * D) m_s[2] = d;
            if (m_off == 3 * D) begin
                for (int b = 0; b < W; b++)
                    m_dout[b] = (int'(m_s[0][b]) + int'(m_s[1][b]) + int'(m_s[2][b])) >= 2;
                m_split = !((m_s[0] == m_s[1]) && (m_s[1] == m_s[2]));
                m_vld   = 1'b1;
                m_busy  = 1'b0;
            end
        end
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (vote_q !== m_dout) begin
            n_bad++;
            $display("FAIL %s vote_q act=%h exp=%h", tag, vote_q, m_dout);
        end
        n_chk++;
        if (vote_vld !== m_vld) begin
            n_bad++;
            $display("FAIL %s vote_vld act=%b exp=%b", tag, vote_vld, m_vld);
        end
        n_chk++;
        if (split_q !== m_split) begin
            n_bad++;
            $display("FAIL %s split_q act=%b exp=%b", tag, split_q, m_split);
        end
    endtask

    // called at a falling edge: drive, model the next rising edge, compare
    task automatic step(input string tag, input bit st, input logic [W-1:0] d);
        start = st;
        din   = d;
        model_edge(st, d);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    // one period: a during [0,D), b during [D,2D), c afterwards;
    // glitch value g replaces din for one cycle at offset goff (-1 none);
    // extra start strobe at offset soff (-1 none)
    task automatic period(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] c, input int goff, input logic [W-1:0] g,
                          input int soff);
        for (int o = 0; o <= 3 * D + 1; o++) begin
            logic [W-1:0] v;
            v = (o < D) ? a : (o < 2 * D) ? b : c;
            if (o == goff) v = g;
            step(tag, (o == 0) || (o == soff), v);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        step("R1", 1'b0, 8'h00);

        // steady input: capture points and commit timing
        period("R5", 8'h3C, 8'h3C, 8'h3C, -1, 8'h00, -1);
        // three distinct words: per-bit vote, flag rises (expect E8)
        period("R4", 8'hF0, 8'hCC, 8'hAA, -1, 8'h00, -1);
        period("R7", 8'h5A, 8'h5A, 8'h5A, -1, 8'h00, -1);
        // R3: offsets checked by values that appear only at one capture
        period("R3", 8'h0F, 8'hF0, 8'hF0, -1, 8'h00, -1);
        period("R2", 8'h81, 8'h7E, 8'h7E, -1, 8'h00, -1);
        // one-cycle glitch on second and third capture instants
        period("R6", 8'h66, 8'h66, 8'h66, D, 8'h99, -1);
        period("R6", 8'h24, 8'h24, 8'h24, 2 * D, 8'hFF, -1);
        // strobes mid-period are ignored
        period("R8", 8'hA5, 8'h11, 8'h11, -1, 8'h00, 1);
        period("R8", 8'hC3, 8'hC3, 8'h3C, -1, 8'h00, 3 * D);
        // idle with changing data
        for (int i = 0; i < 12; i++) step("R9", 1'b0, 8'(i * 37 + 5));
        // back-to-back periods
        period("R5", 8'h01, 8'h01, 8'h01, -1, 8'h00, -1);
        period("R5", 8'hFE, 8'hFE, 8'hFE, -1, 8'h00, -1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule